// File: doc/BRIEF.md
# Feedforward Bit-Period Tracker

This block estimates the real bit period of an incoming serial line whose rate is known only within a tolerance. It runs open-loop. It synchronises the line, marks each transition and counts system clocks between consecutive transitions. It filters out intervals that cannot be a single bit. Intervals that are too short are treated as glitches. Intervals that are too long come from long runs of equal bits.

Within each window of accepted intervals, the shortest one is taken as one bit time. The window minima are averaged, and the result is held inside a band around the nominal period supplied by the user. No oscillator is adjusted in a loop, so the estimate cannot become unstable. The estimate sets the pace of a bit-timing counter. This counter restarts at every transition and produces a one-cycle sample strobe in the middle of each bit, together with the line level taken at that strobe.

The user drives the nominal period on a port and feeds the raw line. Downstream logic takes `sample_bit` whenever `sample_stb` is high. It can trust `period_est` once `est_valid` is set.

Top module: `bit_period_tracker`

## Requirements
- R1: After reset `period_est` equals `nominal_period`, `est_valid` is 0 and `sample_stb` is 0. No strobe occurs until the line has changed at least once.
- R2: The interval between two consecutive line changes is measured in system clocks. The first change after reset only starts measurement. Once a window of WIN_LEN (16) accepted intervals completes, the shortest interval in that window becomes the window minimum, even when longer intervals from multi-bit runs are present.
- R3: `period_est` is the truncated mean of the last 2^AVG_LOG2 (4) window minima. The first completed window fills every history slot with its own minimum.
- R4: An interval longer than 2^LONG_SHIFT (8) times the current `period_est` is rejected. It is not counted toward the window and is not used for the minimum. An interval exactly 8 times the estimate is accepted.
- R5: An interval shorter than floor(`nominal_period`/2) is rejected as a glitch and leaves both the window count and the minimum unchanged.
- R6: Once valid, `period_est` is clamped to the range [`nominal_period` - TOL, `nominal_period` + TOL].
- R7: `est_valid` rises a few cycles after the interval that completes the first window, and it stays high until reset. Before that, `period_est` follows `nominal_period`.
- R8: A line change at input cycle k gives the first strobe at cycle k + 3 + H, where H = max(floor(`period_est`/2), 1). The latency of 3 is two synchroniser stages plus the edge register. Further strobes follow every max(`period_est`, 2) cycles. Each strobe lasts one cycle.
- R9: A line change cancels any pending strobe and restarts the timing from that change. No strobe is issued in the cycle after the change is detected, even if one was due then.
- R10: `sample_bit` holds the synchronised line level captured at each strobe and keeps it between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial line |
| nominal_period | input | CNT_W | Expected bit period in system clocks |
| period_est | output | CNT_W | Corrected bit-period estimate |
| sample_stb | output | 1 | One-cycle mid-bit sample strobe |
| sample_bit | output | 1 | Line level captured at the last strobe |
| est_valid | output | 1 | Estimate based on at least one full window |

## Verification
The bench builds the block with a 16-bit counter, 16-interval windows, a 4-deep average, a tolerance of 8 and a long-interval shift of 3, with a nominal period of 100 clocks. These values keep each window near 1600 clocks, so several windows fit in a short run. With them, the exact rejection threshold (800 accepted, 801 rejected) is reachable, and so are both clamp edges (92 and 108). A running-mean step from 104 toward 96 can be seen as exact integers. The strobe timing is checked to the cycle, including a strobe that would coincide with a line change.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  // Phase of the bit-timing counter.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // no line change seen since reset
    PH_HALF = 2'd1,   // waiting for the mid-bit point after a change
    PH_FULL = 2'd2    // free-running at the full estimated period
  } bit_phase_e;

endpackage

// File: rtl/bpt_edge_timer.sv
module bpt_edge_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  output logic             line_s,
  output logic             edge_o,
  output logic             iv_valid,
  output logic [CNT_W-1:0] iv_len
);

  logic             sync1, sync2, line_d;
  logic             seen;
  logic [CNT_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      line_d <= 1'b0;
    end else begin
      sync1  <= line_in;
      sync2  <= sync1;
      line_d <= sync2;
    end
  end

  assign line_s = sync2;
  assign edge_o = sync2 ^ line_d;

  // gap_cnt holds the clocks elapsed since the previous change; saturates.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      seen     <= 1'b0;
      iv_valid <= 1'b0;
      iv_len   <= '0;
    end else begin
      iv_valid <= 1'b0;
      if (edge_o) begin
        iv_valid <= seen;
        iv_len   <= gap_cnt;
        seen     <= 1'b1;
        gap_cnt  <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (gap_cnt != '1) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  a_r2_interval_follows_edge: assert property (@(posedge clk) disable iff (rst)
    iv_valid |-> $past(edge_o));
  a_r2_interval_nonzero: assert property (@(posedge clk) disable iff (rst)
    iv_valid |-> (iv_len != '0));

endmodule

// File: rtl/bpt_min_window.sv
module bpt_min_window #(
  parameter int CNT_W      = 16,
  parameter int WIN_LEN    = 16,
  parameter int LONG_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iv_valid,
  input  logic [CNT_W-1:0] iv_len,
  input  logic [CNT_W-1:0] nominal_period,
  input  logic [CNT_W-1:0] est,
  output logic             win_done,
  output logic [CNT_W-1:0] win_min
);

  localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int LW = CNT_W + LONG_SHIFT;
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  logic [CW-1:0]    acc_cnt;
  logic [CNT_W-1:0] cur_min, new_min;
  logic [LW-1:0]    long_lim, len_w;
  logic             short_ok, long_ok, accept;

  assign long_lim = {{LONG_SHIFT{1'b0}}, est} << LONG_SHIFT;
  assign len_w    = {{LONG_SHIFT{1'b0}}, iv_len};
  assign short_ok = iv_len >= (nominal_period >> 1);
  assign long_ok  = len_w <= long_lim;
  assign accept   = iv_valid && short_ok && long_ok;
  assign new_min  = (iv_len < cur_min) ? iv_len : cur_min;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cnt  <= '0;
      cur_min  <= '1;
      win_done <= 1'b0;
      win_min  <= '0;
    end else begin
      win_done <= 1'b0;
      if (accept) begin
        if (acc_cnt == LAST) begin
          win_done <= 1'b1;
          win_min  <= new_min;
          acc_cnt  <= '0;
          cur_min  <= '1;
        end else begin
          acc_cnt <= acc_cnt + 1'b1;
          cur_min <= new_min;
        end
      end
    end
  end

  a_r5_min_above_floor: assert property (@(posedge clk) disable iff (rst)
    win_done |-> (win_min >= (nominal_period >> 1)));
  a_r4_min_below_ceiling: assert property (@(posedge clk) disable iff (rst)
    win_done |-> ({{LONG_SHIFT{1'b0}}, win_min} <= long_lim));

endmodule

// File: rtl/bpt_period_avg.sv
module bpt_period_avg #(
  parameter int CNT_W    = 16,
  parameter int AVG_LOG2 = 2,
  parameter int TOL      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_done,
  input  logic [CNT_W-1:0] win_min,
  input  logic [CNT_W-1:0] nominal_period,
  output logic [CNT_W-1:0] period_est,
  output logic             est_valid
);

  localparam int AVG_N = 1 << AVG_LOG2;
  localparam int SW    = CNT_W + AVG_LOG2;
  localparam logic [CNT_W-1:0] TOL_C = CNT_W'(TOL);
  localparam logic [CNT_W-1:0] MAX_C = '1;
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] hist [AVG_N];
  logic             filled;
  logic [SW-1:0]    psum [AVG_N+1];
  logic [SW-1:0]    avg_w;
  logic [CNT_W-1:0] lo_b, hi_b, clamped;

  // History of window minima, newest in slot 0.
  always_ff @(posedge clk) begin
    if (win_done) begin
      for (int i = 0; i < AVG_N; i++) begin
        if (!filled || i == 0) hist[i] <= win_min;
        else                   hist[i] <= hist[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           filled <= 1'b0;
    else if (win_done) filled <= 1'b1;
  end

  assign psum[0] = '0;
  for (genvar g = 0; g < AVG_N; g++) begin : g_sum
    assign psum[g+1] = psum[g] + {{AVG_LOG2{1'b0}}, hist[g]};
  end

  assign avg_w = psum[AVG_N] >> AVG_LOG2;
  assign lo_b  = (nominal_period > TOL_C) ? (nominal_period - TOL_C) : ONE_C;
  assign hi_b  = (nominal_period > (MAX_C - TOL_C)) ? MAX_C : (nominal_period + TOL_C);

  always_comb begin
    if (avg_w > {{AVG_LOG2{1'b0}}, hi_b})      clamped = hi_b;
    else if (avg_w < {{AVG_LOG2{1'b0}}, lo_b}) clamped = lo_b;
    else                                       clamped = avg_w[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_est <= nominal_period;
      est_valid  <= 1'b0;
    end else begin
      period_est <= filled ? clamped : nominal_period;
      est_valid  <= filled;
    end
  end

  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    est_valid |=> est_valid);
  a_r7_nominal_before_valid: assert property (@(posedge clk) disable iff (rst)
    !est_valid |-> (period_est == $past(nominal_period)));
  a_r6_inside_band: assert property (@(posedge clk) disable iff (rst)
    est_valid |-> (period_est >= lo_b && period_est <= hi_b));

endmodule

// File: rtl/bpt_strobe_gen.sv
module bpt_strobe_gen
  import bpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic             line_s,
  input  logic [CNT_W-1:0] est,
  output logic             sample_stb,
  output logic             sample_bit
);

  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_C = CNT_W'(2);

  bit_phase_e       phase;
  logic [CNT_W-1:0] tick, tick_nx, half_t, full_t, tgt;

  assign half_t  = ((est >> 1) == '0) ? ONE_C : (est >> 1);
  assign full_t  = (est < TWO_C) ? TWO_C : est;
  assign tgt     = (phase == PH_HALF) ? half_t : full_t;
  assign tick_nx = tick + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      tick       <= '0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      if (edge_i) begin
        phase <= PH_HALF;
        tick  <= '0;
      end else if (phase != PH_IDLE) begin
        if (tick_nx >= tgt) begin
          sample_stb <= 1'b1;
          sample_bit <= line_s;
          phase      <= PH_FULL;
          tick       <= '0;
        end else begin
          tick <= tick_nx;
        end
      end
    end
  end

  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);
  a_r9_edge_cancels_strobe: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> !sample_stb);
  a_r10_bit_held: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(sample_bit));

endmodule

// File: rtl/bit_period_tracker.sv
module bit_period_tracker #(
  parameter int CNT_W      = 16,
  parameter int WIN_LEN    = 16,
  parameter int AVG_LOG2   = 2,
  parameter int TOL        = 8,
  parameter int LONG_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic [CNT_W-1:0] nominal_period,
  output logic [CNT_W-1:0] period_est,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             est_valid
);

  logic             line_s, edge_w, iv_valid, win_done;
  logic [CNT_W-1:0] iv_len, win_min;

  bpt_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .line_in  (line_in),
    .line_s   (line_s),
    .edge_o   (edge_w),
    .iv_valid (iv_valid),
    .iv_len   (iv_len)
  );

  bpt_min_window #(
    .CNT_W(CNT_W), .WIN_LEN(WIN_LEN), .LONG_SHIFT(LONG_SHIFT)
  ) u_window (
    .clk            (clk),
    .rst            (rst),
    .iv_valid       (iv_valid),
    .iv_len         (iv_len),
    .nominal_period (nominal_period),
    .est            (period_est),
    .win_done       (win_done),
    .win_min        (win_min)
  );

  bpt_period_avg #(
    .CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2), .TOL(TOL)
  ) u_avg (
    .clk            (clk),
    .rst            (rst),
    .win_done       (win_done),
    .win_min        (win_min),
    .nominal_period (nominal_period),
    .period_est     (period_est),
    .est_valid      (est_valid)
  );

  bpt_strobe_gen #(.CNT_W(CNT_W)) u_strobe (
    .clk        (clk),
    .rst        (rst),
    .edge_i     (edge_w),
    .line_s     (line_s),
    .est        (period_est),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit)
  );

endmodule

// File: tb/bit_period_tracker_tb_top.sv
module bit_period_tracker_tb_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             line_in = 1'b0;
  logic [CNT_W-1:0] nominal_period = 16'd100;
  logic [CNT_W-1:0] period_est;
  logic             sample_stb, sample_bit, est_valid;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int last_tog = 0;
  int stb_n = 0;
  int stb_cyc [32];
  logic stb_val [32];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bit_period_tracker #(
    .CNT_W(CNT_W), .WIN_LEN(16), .AVG_LOG2(2), .TOL(8), .LONG_SHIFT(3)
  ) dut_i (
    .clk(clk), .rst(rst), .line_in(line_in), .nominal_period(nominal_period),
    .period_est(period_est), .sample_stb(sample_stb), .sample_bit(sample_bit),
    .est_valid(est_valid)
  );

  always @(negedge clk) begin
    if (!rst && sample_stb && stb_n < 32) begin
      stb_cyc[stb_n] = cyc;
      stb_val[stb_n] = sample_bit;
      stb_n = stb_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    line_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    stb_n = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic toggle_after(input int n);
    repeat (n) @(negedge clk);
    line_in = ~line_in;
    last_tog = cyc;
  endtask

  task automatic send_run(input int count, input int len);
    for (int i = 0; i < count; i++) toggle_after(len);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(period_est == 16'd100, "R1 period after reset", period_est, 100);
    check(est_valid == 1'b0, "R1 valid after reset", est_valid, 0);
    check(sample_stb == 1'b0, "R1 strobe after reset", sample_stb, 0);
    repeat (300) @(negedge clk);
    check(stb_n == 0, "R1 no strobe before any change", stb_n, 0);
  endtask

  task automatic t_strobe_timing();
    int k0, k1, k2;
    int exp_c [7];
    logic exp_b [7];
    do_reset();
    toggle_after(1); k0 = last_tog;
    toggle_after(350); k1 = last_tog;
    toggle_after(180); k2 = last_tog;
    repeat (200) @(negedge clk);
    exp_c[0] = k0 + 53;  exp_b[0] = 1'b1;
    exp_c[1] = k0 + 153; exp_b[1] = 1'b1;
    exp_c[2] = k0 + 253; exp_b[2] = 1'b1;
    exp_c[3] = k1 + 53;  exp_b[3] = 1'b0;
    exp_c[4] = k1 + 153; exp_b[4] = 1'b0;
    exp_c[5] = k2 + 53;  exp_b[5] = 1'b1;
    exp_c[6] = k2 + 153; exp_b[6] = 1'b1;
    // R9: the strobe due at k0+353 coincides with the detected change and is dropped
    check(stb_n == 7, "R9 strobe count with resync", stb_n, 7);
    for (int i = 0; i < 7; i++) begin
      if (i < stb_n) begin
        check(stb_cyc[i] == exp_c[i], "R8 strobe cycle", stb_cyc[i] - k0, exp_c[i] - k0);
        check(stb_val[i] == exp_b[i], "R10 sampled bit", stb_val[i], exp_b[i]);
      end
    end
  endtask

  task automatic t_first_window();
    do_reset();
    toggle_after(1);
    send_run(15, 104);
    repeat (100) @(negedge clk);
    check(est_valid == 1'b0, "R7 not valid before window end", est_valid, 0);
    check(period_est == 16'd100, "R7 nominal before valid", period_est, 100);
    toggle_after(4);
    repeat (10) @(negedge clk);
    check(est_valid == 1'b1, "R7 valid after window end", est_valid, 1);
    check(period_est == 16'd104, "R2 estimate alternating", period_est, 104);
  endtask

  task automatic t_mixed_runs();
    do_reset();
    toggle_after(1);
    for (int i = 0; i < 16; i++) toggle_after(((i % 3) + 1) * 97);
    repeat (10) @(negedge clk);
    check(period_est == 16'd97, "R2 minimum over mixed runs", period_est, 97);
  endtask

  task automatic t_long_reject();
    do_reset();
    toggle_after(1);
    send_run(15, 100);
    toggle_after(801);
    repeat (10) @(negedge clk);
    check(est_valid == 1'b0, "R4 interval 801 rejected", est_valid, 0);
    toggle_after(790);
    repeat (10) @(negedge clk);
    check(est_valid == 1'b1, "R4 interval 800 accepted", est_valid, 1);
    check(period_est == 16'd100, "R4 long interval not minimum", period_est, 100);
  endtask

  task automatic t_glitch_reject();
    do_reset();
    toggle_after(1);
    send_run(8, 104);
    toggle_after(20);
    send_run(8, 104);
    repeat (10) @(negedge clk);
    check(est_valid == 1'b1, "R5 window completes", est_valid, 1);
    check(period_est == 16'd104, "R5 glitch ignored", period_est, 104);
  endtask

  task automatic t_clamp();
    do_reset();
    toggle_after(1);
    send_run(16, 120);
    repeat (10) @(negedge clk);
    check(period_est == 16'd108, "R6 clamp high", period_est, 108);
    do_reset();
    toggle_after(1);
    send_run(16, 80);
    repeat (10) @(negedge clk);
    check(period_est == 16'd92, "R6 clamp low", period_est, 92);
  endtask

  task automatic t_average();
    do_reset();
    toggle_after(1);
    send_run(16, 104);
    repeat (10) @(negedge clk);
    check(period_est == 16'd104, "R3 first window fills history", period_est, 104);
    toggle_after(86);
    send_run(15, 96);
    repeat (10) @(negedge clk);
    check(period_est == 16'd102, "R3 mean after second window", period_est, 102);
    toggle_after(86);
    send_run(15, 96);
    repeat (10) @(negedge clk);
    check(period_est == 16'd100, "R3 mean after third window", period_est, 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_strobe_timing();
    t_first_window();
    t_mixed_runs();
    t_long_reject();
    t_glitch_reject();
    t_clamp();
    t_average();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule